// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

This block holds four 64-bit down-counters that share one clock and one register port. Software programs each counter through a control word and two count words. A counter can run once and stop, or it can wait in a hardware-restart mode for the end-of-count event of the counter with the next lower index. A watchdog-select register picks the counter whose end-of-count event becomes the watchdog expiry pulse.

The intended use pairs two neighbours. The higher counter is the watchdog. It sits in hardware-restart mode and is sourced from the lower counter. The lower counter is a one-shot with a zero count. To ping, software clears and then sets the lower counter's enable. The lower counter then emits its end-of-count event at once, and the watchdog reloads its timeout. The watchdog keeps counting throughout, so no window opens in which it is stopped. A 64-bit count is read as two 32-bit words. Reading the low word captures the high word, so the pair stays consistent while the counter runs.

Top module: `wdb_chain_top`

## Requirements
- R1: After reset every control word, count word, captured high word and the select register read 0, and the expiry output is low.
- R2: Counter n (0 to 3) decodes its control word at byte address n*0x10, its count low word at n*0x10+4 and its captured high word at n*0x10+8. The select register is at 0x40. Any other address reads 0. Control layout: bit 0 enable, bit 1 active (read-only), bits [3:2] mode, bits [7:4] restart source, bits [15:8] prescale.
- R3: A write to a count word updates the reload value. It also updates the live count, but only while the counter's enable is 0.
- R4: In any mode other than 3, a 0-to-1 write of enable sets active and counts down from the live count. When the count is zero the counter raises end-of-count for one cycle, clears active and stays at zero.
- R5: With prescale P, an active counter decrements once every P cycles. P of 0 or 1 gives one decrement per cycle.
- R6: In mode 3 with source 5 and enable set, an end-of-count of counter n-1 reloads the live count from the reload value, sets active and restarts the prescale phase. Enabling in mode 3 does not set active, and counter 0 has no restart source.
- R7: A mode-3 counter that reaches zero raises end-of-count for one cycle and then waits, inactive, for the next restart.
- R8: Reading the low count word captures the live high word. A later read of the high word returns that captured value, even though the counter has moved on.
- R9: Writing enable as 0 clears active and stops counting, and the live count is kept.
- R10: Select bit n routes counter n's end-of-count to the expiry output as a one-cycle pulse. End-of-count events of unselected counters do not reach the output.
- R11: If a restart arrives in the same cycle as the watchdog counter's own end-of-count, the expiry pulse is still produced and the counter reloads and stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, which captures the high word on a low-word read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wd_expire | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Two events can land in the same cycle: a ping that reaches the watchdog counter, and that counter's own expiry. The bench provokes this by repeating the ping with the watchdog's remaining count as the variable, over several values around the three-edge delay of the ping path. In at least one trial the restart and the zero count must coincide. A cycle-accurate reference model judges the result. It expects the expiry pulse in that cycle, and it expects the counter to read back active with its reload value afterwards. The model also counts how often the coincidence occurred, so a run that never hit the corner case is reported.

// File: rtl/wdb_pkg.sv
package wdb_pkg;
    // control word field positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_ACT_BIT  = 1;
    localparam int CTL_MODE_LSB = 2;
    localparam int CTL_SRC_LSB  = 4;
    localparam int CTL_PRE_LSB  = 8;

    // mode and restart source codes
    localparam logic [1:0] MODE_HW_RESTART = 2'd3;
    localparam logic [3:0] SRC_LOWER_CNTR  = 4'd5;

    // word offsets inside a counter's 16-byte window
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_LO   = 4'h4;
    localparam logic [3:0] OFS_HI   = 4'h8;
endpackage

// File: rtl/wdb_counter.sv
module wdb_counter
    import wdb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              lo_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig_in,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] cnt_lo,
    output logic [DATA_W-1:0] hold_hi,
    output logic              endc,
    output logic              en,
    output logic              active
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic               en;
        logic [1:0]         mode;
        logic [3:0]         src;
        logic [PRESC_W-1:0] presc;
        logic               active;
        logic [CNT_W-1:0]   count;
        logic [CNT_W-1:0]   reload;
        logic [PRESC_W-1:0] phase;
        logic [DATA_W-1:0]  hold;
        logic               endc;
    } cnt_state_t;

    cnt_state_t state_q, state_d;
    logic [PRESC_W-1:0] limit;
    logic fire, trig_hit;

    always_comb begin
        state_d       = state_q;
        state_d.endc  = 1'b0;
        limit    = (state_q.presc == '0) ? '0 : state_q.presc - 1'b1;
        fire     = state_q.active && (state_q.count == '0);
        trig_hit = state_q.en && (state_q.mode == MODE_HW_RESTART) &&
                   (state_q.src == SRC_LOWER_CNTR) && trig_in;

        // counting and end-of-count
        if (fire) begin
            state_d.endc   = 1'b1;
            state_d.active = 1'b0;
        end else if (state_q.active) begin
            if (state_q.phase >= limit) begin
                state_d.phase = '0;
                state_d.count = state_q.count - 1'b1;
            end else begin
                state_d.phase = state_q.phase + 1'b1;
            end
        end

        // hardware restart wins over the stop that follows an end-of-count
        if (trig_hit) begin
            state_d.count  = state_q.reload;
            state_d.active = 1'b1;
            state_d.phase  = '0;
        end

        // count word writes: reload always, live count only while disabled
        if (lo_we) begin
            state_d.reload[DATA_W-1:0] = wdata;
            if (!state_q.en) state_d.count[DATA_W-1:0] = wdata;
        end
        if (hi_we) begin
            state_d.reload[CNT_W-1:DATA_W] = wdata;
            if (!state_q.en) state_d.count[CNT_W-1:DATA_W] = wdata;
        end

        // control word write
        if (ctrl_we) begin
            state_d.en    = wdata[CTL_EN_BIT];
            state_d.mode  = wdata[CTL_MODE_LSB +: 2];
            state_d.src   = wdata[CTL_SRC_LSB +: 4];
            state_d.presc = wdata[CTL_PRE_LSB +: PRESC_W];
            if (!wdata[CTL_EN_BIT]) begin
                state_d.active = 1'b0;
            end else if (!state_q.en &&
                         (wdata[CTL_MODE_LSB +: 2] != MODE_HW_RESTART)) begin
                state_d.active = 1'b1;
                state_d.phase  = '0;
            end
        end

        // a low-word read captures the high word
        if (lo_rd) state_d.hold = state_q.count[CNT_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        ctrl_rd                          = '0;
        ctrl_rd[CTL_EN_BIT]              = state_q.en;
        ctrl_rd[CTL_ACT_BIT]             = state_q.active;
        ctrl_rd[CTL_MODE_LSB +: 2]       = state_q.mode;
        ctrl_rd[CTL_SRC_LSB +: 4]        = state_q.src;
        ctrl_rd[CTL_PRE_LSB +: PRESC_W]  = state_q.presc;
    end

    assign cnt_lo  = state_q.count[DATA_W-1:0];
    assign hold_hi = state_q.hold;
    assign endc    = state_q.endc;
    assign en      = state_q.en;
    assign active  = state_q.active;
endmodule

// File: rtl/wdb_rdmux.sv
module wdb_rdmux
    import wdb_pkg::*;
#(
    parameter int NUM_CNTR = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [NUM_CNTR-1:0][DATA_W-1:0]    ctrl_rd,
    input  logic [NUM_CNTR-1:0][DATA_W-1:0]    cnt_lo,
    input  logic [NUM_CNTR-1:0][DATA_W-1:0]    hold_hi,
    input  logic [NUM_CNTR-1:0]                wsel,
    output logic [DATA_W-1:0]                  rdata
);
    localparam int IDX_W = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CNTR * 16);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CNTR; i++) begin
            if (addr[ADDR_W-1:4] == IDX_W'(i)) begin
                case (addr[3:0])
                    OFS_CTRL: rdata = ctrl_rd[i];
                    OFS_LO:   rdata = cnt_lo[i];
                    OFS_HI:   rdata = hold_hi[i];
                    default:  rdata = '0;
                endcase
            end
        end
        if (addr == SEL_ADDR) rdata[NUM_CNTR-1:0] = wsel;
    end
endmodule

// File: rtl/wdb_chain_top.sv
module wdb_chain_top
    import wdb_pkg::*;
#(
    parameter int NUM_CNTR = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int PRESC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_expire
);
    localparam int IDX_W = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CNTR * 16);

    typedef struct packed {
        logic [NUM_CNTR-1:0] wsel;
    } top_state_t;

    top_state_t top_q, top_d;

    logic [NUM_CNTR-1:0] en_vec, act_vec, endc_vec, trig_vec;
    logic [NUM_CNTR-1:0][DATA_W-1:0] ctrl_rd_vec, cnt_lo_vec, hold_vec;
    logic [NUM_CNTR-1:0] wsel_q;

    for (genvar g = 0; g < NUM_CNTR; g++) begin : g_cntr
        logic hit;
        assign hit = (bus_addr[ADDR_W-1:4] == IDX_W'(g));

        if (g == 0) begin : g_first
            assign trig_vec[g] = 1'b0;
        end else begin : g_chain
            assign trig_vec[g] = endc_vec[g-1];
        end

        wdb_counter #(
            .DATA_W  (DATA_W),
            .PRESC_W (PRESC_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (bus_we && hit && (bus_addr[3:0] == OFS_CTRL)),
            .lo_we   (bus_we && hit && (bus_addr[3:0] == OFS_LO)),
            .hi_we   (bus_we && hit && (bus_addr[3:0] == OFS_HI)),
            .lo_rd   (bus_re && hit && (bus_addr[3:0] == OFS_LO)),
            .wdata   (bus_wdata),
            .trig_in (trig_vec[g]),
            .ctrl_rd (ctrl_rd_vec[g]),
            .cnt_lo  (cnt_lo_vec[g]),
            .hold_hi (hold_vec[g]),
            .endc    (endc_vec[g]),
            .en      (en_vec[g]),
            .active  (act_vec[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (bus_we && (bus_addr == SEL_ADDR)) top_d.wsel = bus_wdata[NUM_CNTR-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign wsel_q    = top_q.wsel;
    assign wd_expire = |(wsel_q & endc_vec);

    wdb_rdmux #(
        .NUM_CNTR (NUM_CNTR),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rdmux (
        .addr    (bus_addr),
        .ctrl_rd (ctrl_rd_vec),
        .cnt_lo  (cnt_lo_vec),
        .hold_hi (hold_vec),
        .wsel    (wsel_q),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/wdb_chain_chk.sv
module wdb_chain_chk #(
    parameter int NUM_CNTR = 4,
    parameter int DATA_W   = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_we,
    input logic                             wd_expire,
    input logic [NUM_CNTR-1:0]              en_vec,
    input logic [NUM_CNTR-1:0]              act_vec,
    input logic [NUM_CNTR-1:0]              endc_vec,
    input logic [NUM_CNTR-1:0]              trig_vec,
    input logic [NUM_CNTR-1:0][DATA_W-1:0]  cnt_lo_vec
);
    for (genvar i = 0; i < NUM_CNTR; i++) begin : g_chk
        AST_ACTIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            act_vec[i] |-> en_vec[i]); // R9

        AST_END_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            endc_vec[i] |-> $past(act_vec[i])); // R4

        AST_END_STOPS_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
            (endc_vec[i] && !$past(trig_vec[i])) |-> !act_vec[i]); // R7

        AST_IDLE_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!en_vec[i]) && $past(!bus_we)) |-> (cnt_lo_vec[i] == $past(cnt_lo_vec[i]))); // R9
    end

    AST_EXPIRE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |-> $past(|act_vec)); // R10
endmodule

bind wdb_chain_top wdb_chain_chk #(
    .NUM_CNTR (NUM_CNTR),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .wd_expire  (wd_expire),
    .en_vec     (en_vec),
    .act_vec    (act_vec),
    .endc_vec   (endc_vec),
    .trig_vec   (trig_vec),
    .cnt_lo_vec (cnt_lo_vec)
);

// File: tb/tb_wdb_chain_top.sv
`timescale 1ns/1ps
module tb_wdb_chain_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_expire;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wdb_chain_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_expire (wd_expire)
    );

    // reference model state
    longint unsigned m_cnt[4];
    longint unsigned m_rld[4];
    longint unsigned old_cnt[4];
    bit m_en[4], m_act[4], m_endc[4], old_endc[4], new_endc[4];
    int m_mode[4], m_src[4], m_presc[4], m_pre[4];
    int unsigned m_hold[4];
    int m_wsel;
    int coinc;
    int widx, wofs, lim;
    bit fire, trg;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_rld[i] = 0; m_en[i] = 0; m_act[i] = 0; m_endc[i] = 0;
                m_mode[i] = 0; m_src[i] = 0; m_presc[i] = 0; m_pre[i] = 0; m_hold[i] = 0;
            end
            m_wsel = 0;
            coinc = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                old_cnt[i] = m_cnt[i];
                old_endc[i] = m_endc[i];
            end
            for (int i = 0; i < 4; i++) begin
                fire = m_act[i] && (m_cnt[i] == 0);
                new_endc[i] = fire;
                if (fire) m_act[i] = 0;
                else if (m_act[i]) begin
                    lim = (m_presc[i] == 0) ? 0 : m_presc[i] - 1;
                    if (m_pre[i] >= lim) begin m_pre[i] = 0; m_cnt[i] = m_cnt[i] - 1; end
                    else m_pre[i] = m_pre[i] + 1;
                end
                trg = (i > 0) ? old_endc[i-1] : 1'b0;
                if (m_en[i] && m_mode[i] == 3 && m_src[i] == 5 && trg) begin
                    if (fire) coinc++;
                    m_cnt[i] = m_rld[i]; m_act[i] = 1; m_pre[i] = 0;
                end
            end
            widx = int'(bus_addr[7:4]);
            wofs = int'(bus_addr[3:0]);
            if (bus_we) begin
                if (bus_addr == 8'h40) m_wsel = int'(bus_wdata[3:0]);
                else if (widx < 4) begin
                    if (wofs == 4) begin
                        m_rld[widx][31:0] = bus_wdata;
                        if (!m_en[widx]) m_cnt[widx][31:0] = bus_wdata;
                    end else if (wofs == 8) begin
                        m_rld[widx][63:32] = bus_wdata;
                        if (!m_en[widx]) m_cnt[widx][63:32] = bus_wdata;
                    end else if (wofs == 0) begin
                        if (!bus_wdata[0]) m_act[widx] = 0;
                        else if (!m_en[widx] && bus_wdata[3:2] != 2'd3) begin
                            m_act[widx] = 1; m_pre[widx] = 0;
                        end
                        m_en[widx] = bus_wdata[0];
                        m_mode[widx] = int'(bus_wdata[3:2]);
                        m_src[widx] = int'(bus_wdata[7:4]);
                        m_presc[widx] = int'(bus_wdata[15:8]);
                    end
                end
            end
            if (bus_re && widx < 4 && wofs == 4) m_hold[widx] = old_cnt[widx][63:32];
            for (int i = 0; i < 4; i++) m_endc[i] = new_endc[i];
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int idx = int'(a[7:4]);
        int ofs = int'(a[3:0]);
        logic [31:0] v = '0;
        if (a == 8'h40) v = 32'(m_wsel);
        else if (idx < 4) begin
            if (ofs == 0) v = 32'((m_presc[idx] << 8) | (m_src[idx] << 4) | (m_mode[idx] << 2) |
                                  (int'(m_act[idx]) << 1) | int'(m_en[idx]));
            else if (ofs == 4) v = m_cnt[idx][31:0];
            else if (ofs == 8) v = m_hold[idx];
        end
        return v;
    endfunction

    function automatic bit m_expire();
        bit e = 0;
        for (int i = 0; i < 4; i++) if (m_wsel[i] && m_endc[i]) e = 1;
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    // R10: expiry output against the model on every clock
    always @(negedge clk) begin
        if (rst_n) chk(wd_expire == m_expire(), "R10 expiry pulse", 32'(wd_expire), 32'(m_expire()));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nerr++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        bus_addr = a; bus_re = 1'b1;
        #1;
        e = m_read(a);
        chk(bus_rdata == e, tag, bus_rdata, e);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ping();
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h1);
    endtask

    localparam logic [31:0] WD_CTRL = (32'd5 << 4) | (32'd3 << 2) | 32'd1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: reset values and map, including unmapped addresses
        for (int i = 0; i < 4; i++) begin
            rd(8'(i * 16), "R1 ctrl after reset");
            rd(8'(i * 16 + 4), "R1 low after reset");
            rd(8'(i * 16 + 8), "R1 high after reset");
        end
        rd(8'h40, "R1 select after reset");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, "R2 unmapped offset");
        rd(8'h50, "R2 unmapped window");
        rd(8'h04, "R2 stray write ignored");

        // R4, R10: one-shot counter 2, selected
        wr(8'h24, 32'd9);
        wr(8'h28, 32'd0);
        rd(8'h24, "R3 write while disabled");
        wr(8'h40, 32'h4);
        wr(8'h20, 32'h1);
        for (int k = 0; k < 14; k++) rd(8'h24, "R4 one-shot countdown");
        rd(8'h20, "R4 inactive after end");

        // R3: write while enabled only changes reload
        wr(8'h24, 32'd30);
        rd(8'h24, "R3 enabled write keeps count");
        wr(8'h20, 32'h0);
        wr(8'h24, 32'd7);
        rd(8'h24, "R3 disabled write loads count");

        // R5: prescale 3 on counter 3, unselected (R10)
        wr(8'h34, 32'd6);
        wr(8'h38, 32'd0);
        wr(8'h30, (32'd3 << 8) | 32'd1);
        for (int k = 0; k < 12; k++) rd(8'h34, "R5 prescaled countdown");

        // R9: disable keeps the count
        wr(8'h34, 32'd40);
        wr(8'h30, (32'd3 << 8) | 32'd1);
        idle(4);
        wr(8'h30, 32'h300);
        rd(8'h34, "R9 count after disable");
        idle(5);
        rd(8'h34, "R9 count held");
        rd(8'h30, "R9 active cleared");

        // R8: high word capture across a borrow
        wr(8'h34, 32'd2);
        wr(8'h38, 32'd1);
        wr(8'h30, 32'h1);
        rd(8'h34, "R8 low read");
        idle(3);
        rd(8'h38, "R8 captured high");
        for (int k = 0; k < 3; k++) rd(8'h34, "R8 low read");
        rd(8'h38, "R8 captured high after borrow");
        wr(8'h30, 32'h0);

        // R6, R7: watchdog on counter 1, pinged by counter 0
        wr(8'h40, 32'h2);
        wr(8'h14, 32'd20);
        wr(8'h18, 32'd0);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'd0);
        wr(8'h10, WD_CTRL);
        rd(8'h10, "R6 enable in restart mode stays inactive");
        wr(8'h00, 32'h1);
        idle(2);
        rd(8'h10, "R6 started by lower end-count");
        for (int k = 0; k < 5; k++) begin
            idle(8);
            ping();
            rd(8'h14, "R6 ping reloads");
        end
        idle(30);
        rd(8'h10, "R7 inactive after expiry");
        rd(8'h14, "R7 count at zero");

        // R3: new reload taken on the next ping
        wr(8'h14, 32'd10);
        rd(8'h14, "R3 reload only while enabled");
        ping();
        idle(1);
        rd(8'h14, "R3 new reload after ping");

        // R11: ping lands on the watchdog's own end-count
        for (int t = 1; t <= 5; t++) begin
            ping();
            for (int w = 0; w < 40 && !(m_act[1] && m_cnt[1] == longint'(t)); w++) @(negedge clk);
            ping();
            idle(2);
            rd(8'h10, "R11 state after coincident ping");
            rd(8'h14, "R11 count after coincident ping");
            idle(14);
        end
        chk(coinc > 0, "R11 coincidence reached", 32'(coinc), 32'd1);

        idle(3);
        summary();
        $finish;
    end
endmodule